// File: doc/BRIEF.md
# RAM Shadow-Logic Scan Bypass Wrapper

This block wraps a single-port synchronous RAM so that automatic test pattern generation can reach the combinational logic on both sides of the memory, while the memory itself is modelled as an opaque box. During scan testing, a parity fold of the RAM's address and write-data inputs replaces the read data. The logic that feeds the RAM's inputs can then be observed, and the logic that consumes its outputs can be controlled, through a path with no state in it.

The fold has one output for each read-data bit. Output bit `i` is write-data bit `i`, XORed with every address bit `j` for which `j mod DATA_W == i`. No clock, reset, write enable or chip select reaches the fold. An active-high `scan_mode` input selects, bit by bit, between the fold and the registered RAM read data. In functional mode the read is synchronous with one cycle of latency, and the only added cost is one 2:1 multiplexer per data bit. A behavioural RAM model of parameterised width and depth is included, so the wrapper can be simulated on its own.

Top module: `sbp_shadow_wrap`

## Requirements
- R1: A cycle with `rst` high at a rising clock edge clears the RAM read register. With `scan_mode` low, `rdata` reads 0 after that edge until the next read completes.
- R2: With `scan_mode` high, `rdata[i]` equals `wdata[i]` XOR the XOR of all `addr[j]` with `j mod DATA_W == i`. It follows changes on `addr` or `wdata` within the same cycle, with no clock edge needed.
- R3: With `scan_mode` high, changing `we` or `cs`, or applying clock edges, leaves `rdata` unchanged while `addr` and `wdata` are held.
- R4: With `scan_mode` low, a read (`cs`=1, `we`=0) of a written address presents the stored word on `rdata` after the next rising edge.
- R5: A write cycle (`cs`=1, `we`=1) stores `wdata` at `addr` and leaves the read register, and so `rdata` in functional mode, unchanged.
- R6: With `cs` low, no write takes place and the read register holds its value, whatever the state of `we`, `addr` or `wdata`.
- R7: Lowering `scan_mode` immediately presents the read register's held value again; the bypass path stores nothing.
- R8: Address bits at positions `DATA_W` and above wrap onto the outputs. With the default parameters (`DATA_W`=8, depth 512), address bit 8 alone drives `rdata[0]` high in scan mode when `wdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RAM clock |
| rst | input | 1 | Synchronous active-high reset of the read register |
| scan_mode | input | 1 | 1 selects the parity fold, 0 selects RAM read data |
| cs | input | 1 | RAM chip select |
| we | input | 1 | Write enable, 1 = write, 0 = read |
| addr | input | ADDR_W | Word address, ADDR_W = clog2(DEPTH) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data to the output-side logic |

## Verification
In scan mode the bench applies random address and data words, which tell a correct fold apart from a swapped or dropped bit. Single-bit addresses above the data width separate a correct wrap from a truncated fold. Toggling the enables while address and data are held shows that no control net leaks into the fold. In functional mode, write/read sequences with interleaved writes, deselected write attempts and scan-mode pulses separate correct read latency from a read register that is overwritten or cleared at the wrong time.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

    localparam int SBP_DATA_W = 8;
    localparam int SBP_DEPTH  = 512;

    typedef enum logic {
        PATH_RAM    = 1'b0,
        PATH_BYPASS = 1'b1
    } sbp_path_e;

    typedef struct packed {
        logic sel;
        logic wr;
    } sbp_ctl_t;

    function automatic sbp_path_e path_of(input logic scan);
        return scan ? PATH_BYPASS : PATH_RAM;
    endfunction

endpackage

// File: rtl/sbp_ram_model.sv
module sbp_ram_model #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 512,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  sbp_pkg::sbp_ctl_t     ctl,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     q
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Storage array: written only on selected write cycles.
    always_ff @(posedge clk) begin
        if (ctl.sel && ctl.wr) begin
            mem[addr] <= wdata;
        end
    end

    // Read register: cleared by reset, loaded only on selected read cycles.
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (ctl.sel && !ctl.wr) begin
            q <= mem[addr];
        end
    end
endmodule

// File: rtl/sbp_xor_fold.sv
module sbp_xor_fold #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] fold
);
    // Address bit j lands on output j mod DATA_W; only data and address lines enter.
    always_comb begin
        fold = wdata;
        for (int j = 0; j < ADDR_W; j++) begin
            fold[j % DATA_W] = fold[j % DATA_W] ^ addr[j];
        end
    end
endmodule

// File: rtl/sbp_out_mux.sv
module sbp_out_mux #(
    parameter int DATA_W = 8
) (
    input  sbp_pkg::sbp_path_e  path,
    input  logic [DATA_W-1:0]   ram_q,
    input  logic [DATA_W-1:0]   fold,
    output logic [DATA_W-1:0]   rdata
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign rdata[i] = (path == sbp_pkg::PATH_BYPASS) ? fold[i] : ram_q[i];
    end
endmodule

// File: rtl/sbp_shadow_wrap.sv
module sbp_shadow_wrap #(
    parameter int DATA_W = sbp_pkg::SBP_DATA_W,
    parameter int DEPTH  = sbp_pkg::SBP_DEPTH,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_mode,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    sbp_pkg::sbp_ctl_t  ctl;
    sbp_pkg::sbp_path_e path;
    logic [DATA_W-1:0]  ram_q;
    logic [DATA_W-1:0]  fold;

    assign ctl.sel = cs;
    assign ctl.wr  = we;
    assign path    = sbp_pkg::path_of(scan_mode);

    sbp_ram_model #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_ram (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .addr  (addr),
        .wdata (wdata),
        .q     (ram_q)
    );

    sbp_xor_fold #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_fold (
        .addr  (addr),
        .wdata (wdata),
        .fold  (fold)
    );

    sbp_out_mux #(.DATA_W(DATA_W)) i_mux (
        .path  (path),
        .ram_q (ram_q),
        .fold  (fold),
        .rdata (rdata)
    );
endmodule

// File: rtl/sbp_shadow_chk.sv
module sbp_shadow_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              scan_mode,
    input logic              cs,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b1;
    end

    // R1: read data is zero in the cycle after reset
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!armed)
        ($past(rst) && !rst && !scan_mode) |-> (rdata == '0));

    // R2: every address bit reaches exactly one output, so overall parity is kept
    a_r2_parity_kept: assert property (@(posedge clk) disable iff (rst || !armed)
        scan_mode |-> ((^rdata) == ((^wdata) ^ (^addr))));

    // R3: held address and data give held bypass output
    a_r3_bypass_stateless: assert property (@(posedge clk) disable iff (rst || !armed)
        (scan_mode && $past(scan_mode) && !$past(rst) && $stable(addr) && $stable(wdata))
            |-> $stable(rdata));

    // R5: write cycle leaves functional read data untouched
    a_r5_write_holds: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(cs && we) && !$past(rst) && !scan_mode && !$past(scan_mode)) |-> $stable(rdata));

    // R6: deselected cycle leaves functional read data untouched
    a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(!cs) && !$past(rst) && !scan_mode && !$past(scan_mode)) |-> $stable(rdata));
endmodule

bind sbp_shadow_wrap sbp_shadow_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .scan_mode (scan_mode),
    .cs        (cs),
    .we        (we),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata)
);

// File: tb/test_sbp_shadow_wrap.sv
module test_sbp_shadow_wrap;
    localparam int DW = 8;
    localparam int AW = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scan_mode = 1'b0;
    logic          cs = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    logic [DW-1:0] mem [int];
    logic [DW-1:0] mq = '0;
    bit            known = 1'b0;

    always #10 clk = ~clk;

    sbp_shadow_wrap i_sbp_shadow_wrap (
        .clk(clk), .rst(rst), .scan_mode(scan_mode), .cs(cs), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [DW-1:0] ref_fold(input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] r = d;
        for (int j = 0; j < AW; j++) r[j % DW] = r[j % DW] ^ a[j];
        return r;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rdata=%h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model, compared every clock
    always @(posedge clk) begin
        if (rst) begin
            mq = '0; known = 1'b1;
        end else if (cs) begin
            if (we) mem[int'(addr)] = wdata;
            else if (mem.exists(int'(addr))) begin mq = mem[int'(addr)]; known = 1'b1; end
            else known = 1'b0;
        end
        #5;
        if (!done) begin
            if (scan_mode) check(cur_req, rdata, ref_fold(addr, wdata));
            else if (known) check(cur_req, rdata, mq);
        end
    end

    task automatic cyc(input logic c, input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cs = c; we = w; addr = a; wdata = d;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: rdata=%h expected completion", rdata);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] held;
        // R1 reset
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1 check("R1", rdata, '0);

        // R2 scan mode with random stimulus
        cur_req = "R2";
        scan_mode = 1'b1;
        for (int k = 0; k < 200; k++) begin
            cyc(1'($urandom), 1'($urandom), AW'($urandom), DW'($urandom));
            #1 check("R2", rdata, ref_fold(addr, wdata));
        end
        // R2 same-cycle response between edges
        @(posedge clk); #3;
        addr = 9'h0A5; wdata = 8'h3C;
        #1 check("R2", rdata, ref_fold(9'h0A5, 8'h3C));

        // R8 wrap of high address bits
        cur_req = "R8";
        cyc(1'b0, 1'b0, 9'h100, 8'h00);
        #1 check("R8", rdata, 8'h01);
        cyc(1'b0, 1'b0, 9'h180, 8'h00);
        #1 check("R8", rdata, 8'h81);

        // R3 control nets do not reach the fold
        cur_req = "R3";
        cyc(1'b0, 1'b0, 9'h15A, 8'hC3);
        held = rdata;
        #1 held = rdata;
        check("R3", held, ref_fold(9'h15A, 8'hC3));
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cs = k[0]; we = k[1];
            #1 check("R3", rdata, held);
        end

        // R5 fill memory in functional mode
        cur_req = "R5";
        scan_mode = 1'b0;
        cyc(1'b0, 1'b0, '0, '0);
        for (int k = 0; k < 32; k++) cyc(1'b1, 1'b1, AW'(k * 13), DW'($urandom));

        // R4 read back
        cur_req = "R4";
        for (int k = 0; k < 32; k++) cyc(1'b1, 1'b0, AW'(k * 13), '0);
        for (int k = 0; k < 40; k++) cyc(1'b1, 1'b0, AW'(($urandom % 32) * 13), DW'($urandom));

        // R4 explicit latency, then R5 explicit hold during write
        cyc(1'b1, 1'b1, 9'h1F0, 8'h5A);
        cyc(1'b1, 1'b0, 9'h1F0, 8'h00);
        cyc(1'b1, 1'b1, 9'h1F1, 8'hA7);
        #1 check("R4", rdata, 8'h5A);
        cyc(1'b0, 1'b0, 9'h1F1, 8'h00);
        #1 check("R5", rdata, 8'h5A);

        // R6 deselected write attempt and hold
        cur_req = "R6";
        cyc(1'b0, 1'b1, 9'h1F0, 8'hFF);
        cyc(1'b0, 1'b0, 9'h1F1, 8'h11);
        #1 check("R6", rdata, 8'h5A);
        cyc(1'b1, 1'b0, 9'h1F0, 8'h00);
        cyc(1'b0, 1'b0, 9'h000, 8'h00);
        #1 check("R6", rdata, 8'h5A);
        cyc(1'b1, 1'b0, 9'h1F1, 8'h00);
        cyc(1'b0, 1'b0, 9'h000, 8'h00);
        #1 check("R6", rdata, 8'hA7);

        // R7 scan pulse does not disturb held read data
        cur_req = "R7";
        @(posedge clk); #3;
        scan_mode = 1'b1; addr = 9'h0FF; wdata = 8'h0F;
        #1 check("R7", rdata, ref_fold(9'h0FF, 8'h0F));
        #2 scan_mode = 1'b0;
        #1 check("R7", rdata, 8'hA7);

        // R1 reset in the middle of operation
        cur_req = "R1";
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1 check("R1", rdata, '0);
        @(negedge clk);
        #1 check("R1", rdata, '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule